// File: doc/BRIEF.md
# Tamper Detection Rule Engine

This block watches a set of synchronous digital flags from the metering front end and from the board: a cover switch, a high magnetic field, a power-factor or phase anomaly, a reversed energy sign, an implausible voltage/current relationship, an abnormal current-consistency flag, a firmware version mismatch and a marginal-rail warning. Seven independent rules turn these flags into typed tamper events. Each rule has its own duration gate. High-impact claims need a second, correlated flag. After a rule fires, its flag must stay clear for a hold time before the rule can arm again.

A firing rule has two effects in the same cycle. It raises a one-cycle pending strobe with a mask of the rules that just fired, so the log writer can store a short "tamper pending" marker at once. While any rule is active, a transmit-freeze level stays high. The full evidence follows later on a valid/ready stream. Each rule produces one start record and one end record, and each record carries the type, the severity, the duration and an eight-bit flag snapshot. The log writer applies back-pressure by holding ready low, for example while hold-up energy is uncertain. Requests wait in per-rule pending bits and none is lost. While valid is high and ready is low, the record on the stream stays unchanged. A record transfers on a clock edge where valid and ready are both high.

Top module: `tamper_rule_engine`

## Requirements
- R1: The magnet event (type code 0) starts only after the field-high flag and the PF/phase anomaly flag have both been high for gate_mag_i+1 consecutive cycles. Its severity is 2 (high).
- R2: The reverse-current event (type 2) starts after rev_sign_i has been high for gate_rev_i+1 consecutive cycles. A shorter run produces no event. Its severity is 1 (normal).
- R3: The suspected-bypass event (type 4) starts after cur_bad_i has been high for gate_byp_i+1 consecutive cycles.
- R4: If vi_bad_i is held for gate_vi_i+1 cycles without the PF anomaly, the neutral-missing event (type 1) starts. If it is held together with the PF anomaly, the suspected-injection event (type 5) starts. The PF anomaly alone raises nothing.
- R5: The cover-open event (type 3) follows the debounced cover input. A raw level counts only after it has been stable for DEB_CYC samples, so shorter glitches raise nothing. Severity is 2 if vi_bad_i, cur_bad_i or pf_anom_i is high when the event starts, and 1 otherwise.
- R6: The firmware-rollback event (type 6) starts in the first cycle after a mismatch is seen. It is reported once for each continuous mismatch, with severity 2.
- R7: If rail_low_i is high when a rule starts, the event carries severity 0 (weak), whatever its type.
- R8: Every start record (ev_start_o=1) carries duration 0. The matching end record (ev_start_o=0) carries the number of cycles the rule's condition was high, including the gate.
- R9: After an end, a rule starts again only once its condition has stayed low for HOLD_CYC consecutive cycles. If the condition rises again during that wait, the wait restarts and no new start is raised.
- R10: Requests raised in the same cycle are all delivered, with no drops. Rules are served in type-code order, and all pending starts go ahead of any pending end. While ev_valid_o is high and ev_ready_i is low, the record holds steady.
- R11: pend_stb_o pulses for exactly the cycle in which any rule enters its active state. pend_mask_o has bit k set for each rule k that enters in that cycle. tx_freeze_o is high while any rule is active.
- R12: After reset, ev_valid_o, pend_stb_o and tx_freeze_o are low.
- R13: The snapshot bits are: 0 magnet, 1 PF anomaly, 2 reverse sign, 3 V/I inconsistency, 4 current inconsistency, 5 debounced cover, 6 firmware mismatch, 7 rail low. They are captured when the rule starts and repeated in its end record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cover_raw_i | input | 1 | Raw cover switch, 1 = open |
| mag_high_i | input | 1 | Magnetic field above threshold |
| pf_anom_i | input | 1 | Metrology PF/phase anomaly |
| rev_sign_i | input | 1 | Energy direction reversed |
| vi_bad_i | input | 1 | Implausible voltage/current relationship |
| cur_bad_i | input | 1 | Abnormal current consistency |
| fw_mismatch_i | input | 1 | Firmware version counter mismatch |
| rail_low_i | input | 1 | Supply rail marginal |
| gate_mag_i | input | CNT_W | Magnet duration gate |
| gate_rev_i | input | CNT_W | Reverse-current duration gate |
| gate_byp_i | input | CNT_W | Bypass duration gate |
| gate_vi_i | input | CNT_W | Neutral/injection duration gate |
| pend_stb_o | output | 1 | Pending-marker strobe |
| pend_mask_o | output | 7 | Rules that fired this cycle |
| tx_freeze_o | output | 1 | Transmit freeze request |
| ev_valid_o | output | 1 | Evidence record valid |
| ev_ready_i | input | 1 | Log writer ready |
| ev_start_o | output | 1 | 1 = start record, 0 = end record |
| ev_type_o | output | 3 | Event type code |
| ev_lvl_o | output | 2 | Severity: 0 weak, 1 normal, 2 high |
| ev_dur_o | output | CNT_W+1 | Duration in cycles (end records) |
| ev_snap_o | output | 8 | Flag snapshot |

## Verification
The assertions assume that every flag input is already synchronous to clk and that the gate inputs are held constant while a rule is counting. A gate that changes in the middle of a count would make the measured run ambiguous. The stimulus changes flags and gates only on falling clock edges, and it writes the gates only while every rule is idle or waiting to re-arm. The stream assertions also assume that the log writer may hold ready low for any length of time. The bench uses this by holding ready low while several records queue up.

// File: rtl/tre_pkg.sv
package tre_pkg;
  localparam int unsigned NUM_RULES = 7;
  localparam int unsigned SNAP_W    = 8;

  typedef enum logic [2:0] {
    EV_MAGNET  = 3'd0,
    EV_NEUTRAL = 3'd1,
    EV_REVERSE = 3'd2,
    EV_COVER   = 3'd3,
    EV_BYPASS  = 3'd4,
    EV_INJECT  = 3'd5,
    EV_FWROLL  = 3'd6
  } ev_type_e;

  typedef enum logic [1:0] {
    LVL_WEAK = 2'd0,
    LVL_NORM = 2'd1,
    LVL_HIGH = 2'd2
  } ev_lvl_e;

  localparam int unsigned SB_MAG   = 0;
  localparam int unsigned SB_PF    = 1;
  localparam int unsigned SB_REV   = 2;
  localparam int unsigned SB_VI    = 3;
  localparam int unsigned SB_CUR   = 4;
  localparam int unsigned SB_COVER = 5;
  localparam int unsigned SB_FW    = 6;
  localparam int unsigned SB_RAIL  = 7;
endpackage

// File: rtl/tre_debounce.sv
module tre_debounce #(
  parameter int DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic stable_o
);
  localparam int DW = $clog2(DEB_CYC + 1);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stable_o <= 1'b0;
      cnt      <= '0;
    end else if (raw_i != stable_o) begin
      if (cnt == DW'(DEB_CYC - 1)) begin
        stable_o <= raw_i;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  // R5: a debounced change always adopts a level the raw input held
  a_r5_deb_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stable_o) |-> ($past(raw_i) == stable_o));
endmodule

// File: rtl/tre_rule.sv
module tre_rule import tre_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int DUR_W    = 17,
  parameter int HOLD_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cond_i,
  input  logic [CNT_W-1:0]  gate_i,
  input  logic [1:0]        lvl_i,
  input  logic [SNAP_W-1:0] snap_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic              end_o,
  output logic              active_o,
  output logic [1:0]        lvl_o,
  output logic [SNAP_W-1:0] snap_o,
  output logic [DUR_W-1:0]  dur_o
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_REARM} rule_st_e;
  rule_st_e          st;
  logic [CNT_W-1:0]  cnt;
  logic [HOLD_W-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      hcnt    <= '0;
      dur_o   <= '0;
      lvl_o   <= LVL_WEAK;
      snap_o  <= '0;
      start_o <= 1'b0;
      end_o   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      end_o   <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (cond_i) begin
            if (cnt == gate_i) begin
              st      <= S_ACT;
              start_o <= 1'b1;
              cnt     <= '0;
              dur_o   <= DUR_W'(gate_i) + DUR_W'(1);
              lvl_o   <= lvl_i;
              snap_o  <= snap_i;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            cnt <= '0;
          end
        end
        S_ACT: begin
          if (cond_i) begin
            if (dur_o != '1) dur_o <= dur_o + 1'b1;
          end else begin
            end_o <= 1'b1;
            st    <= S_REARM;
            hcnt  <= '0;
          end
        end
        S_REARM: begin
          if (cond_i) begin
            hcnt <= '0;
          end else if (hcnt == HOLD_W'(HOLD_CYC - 1)) begin
            if (!busy_i) st <= S_IDLE;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign active_o = (st == S_ACT);

  a_r2_start_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(cond_i));
  a_r8_end_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> !$past(cond_i));
  a_r8_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && end_o));
  a_r9_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
endmodule

// File: rtl/tre_evq.sv
module tre_evq import tre_pkg::*; #(
  parameter int N     = 7,
  parameter int DUR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      start_i,
  input  logic [N-1:0]      end_i,
  input  logic [1:0]        lvl_i  [N],
  input  logic [SNAP_W-1:0] snap_i [N],
  input  logic [DUR_W-1:0]  dur_i  [N],
  output logic [N-1:0]      busy_o,
  output logic              ev_valid_o,
  input  logic              ev_ready_i,
  output logic              ev_start_o,
  output logic [2:0]        ev_type_o,
  output logic [1:0]        ev_lvl_o,
  output logic [DUR_W-1:0]  ev_dur_o,
  output logic [SNAP_W-1:0] ev_snap_o
);
  localparam int REQ   = 2 * N;
  localparam int SEL_W = $clog2(REQ);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]     pend_s, pend_e;
  logic [REQ-1:0]   req, gnt;
  logic [SEL_W-1:0] sel;
  logic             found, load, sel_start;
  logic [IDX_W-1:0] ridx;

  assign req = {pend_e, pend_s};

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < REQ; i++) begin
      if (req[i] && !found) begin
        found = 1'b1;
        sel   = SEL_W'(i);
      end
    end
  end

  assign gnt       = found ? (REQ'(1) << sel) : '0;
  assign load      = found && (!ev_valid_o || ev_ready_i);
  assign sel_start = (sel < SEL_W'(N));
  assign ridx      = sel_start ? IDX_W'(sel) : IDX_W'(sel - SEL_W'(N));
  assign busy_o    = pend_s | pend_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_s     <= '0;
      pend_e     <= '0;
      ev_valid_o <= 1'b0;
      ev_start_o <= 1'b0;
      ev_type_o  <= '0;
      ev_lvl_o   <= '0;
      ev_dur_o   <= '0;
      ev_snap_o  <= '0;
    end else begin
      pend_s <= (pend_s | start_i) & ~(load ? gnt[N-1:0] : '0);
      pend_e <= (pend_e | end_i) & ~(load ? gnt[REQ-1:N] : '0);
      if (load) begin
        ev_valid_o <= 1'b1;
        ev_start_o <= sel_start;
        ev_type_o  <= 3'(ridx);
        ev_lvl_o   <= lvl_i[ridx];
        ev_snap_o  <= snap_i[ridx];
        ev_dur_o   <= sel_start ? '0 : dur_i[ridx];
      end else if (ev_ready_i) begin
        ev_valid_o <= 1'b0;
      end
    end
  end

  a_r10_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && !ev_ready_i) |=> (ev_valid_o &&
      $stable({ev_start_o, ev_type_o, ev_lvl_o, ev_dur_o, ev_snap_o})));
  a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r10_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_i & pend_s) == '0) && ((end_i & pend_e) == '0));
endmodule

// File: rtl/tamper_rule_engine.sv
module tamper_rule_engine import tre_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int DEB_CYC  = 4,
  parameter int HOLD_CYC = 8,
  localparam int DUR_W   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cover_raw_i,
  input  logic             mag_high_i,
  input  logic             pf_anom_i,
  input  logic             rev_sign_i,
  input  logic             vi_bad_i,
  input  logic             cur_bad_i,
  input  logic             fw_mismatch_i,
  input  logic             rail_low_i,
  input  logic [CNT_W-1:0] gate_mag_i,
  input  logic [CNT_W-1:0] gate_rev_i,
  input  logic [CNT_W-1:0] gate_byp_i,
  input  logic [CNT_W-1:0] gate_vi_i,
  output logic             pend_stb_o,
  output logic [6:0]       pend_mask_o,
  output logic             tx_freeze_o,
  output logic             ev_valid_o,
  input  logic             ev_ready_i,
  output logic             ev_start_o,
  output logic [2:0]       ev_type_o,
  output logic [1:0]       ev_lvl_o,
  output logic [DUR_W-1:0] ev_dur_o,
  output logic [7:0]       ev_snap_o
);
  localparam int N = NUM_RULES;

  logic              cover_deb;
  logic [N-1:0]      cond, start_p, end_p, active, busy;
  logic [CNT_W-1:0]  gate [N];
  logic [1:0]        base_lvl [N];
  logic [1:0]        lvl_in [N];
  logic [1:0]        lvl_q [N];
  logic [SNAP_W-1:0] snap_q [N];
  logic [DUR_W-1:0]  dur_q [N];
  logic [SNAP_W-1:0] snap_now;

  tre_debounce #(.DEB_CYC(DEB_CYC)) i_cover_deb (
    .clk(clk), .rst_n(rst_n), .raw_i(cover_raw_i), .stable_o(cover_deb)
  );

  assign snap_now = {rail_low_i, fw_mismatch_i, cover_deb, cur_bad_i,
                     vi_bad_i, rev_sign_i, pf_anom_i, mag_high_i};

  always_comb begin
    cond[EV_MAGNET]  = mag_high_i & pf_anom_i;
    cond[EV_NEUTRAL] = vi_bad_i & ~pf_anom_i;
    cond[EV_REVERSE] = rev_sign_i;
    cond[EV_COVER]   = cover_deb;
    cond[EV_BYPASS]  = cur_bad_i;
    cond[EV_INJECT]  = vi_bad_i & pf_anom_i;
    cond[EV_FWROLL]  = fw_mismatch_i;

    gate[EV_MAGNET]  = gate_mag_i;
    gate[EV_NEUTRAL] = gate_vi_i;
    gate[EV_REVERSE] = gate_rev_i;
    gate[EV_COVER]   = '0;
    gate[EV_BYPASS]  = gate_byp_i;
    gate[EV_INJECT]  = gate_vi_i;
    gate[EV_FWROLL]  = '0;

    base_lvl[EV_MAGNET]  = LVL_HIGH;
    base_lvl[EV_NEUTRAL] = LVL_NORM;
    base_lvl[EV_REVERSE] = LVL_NORM;
    base_lvl[EV_COVER]   = (vi_bad_i | cur_bad_i | pf_anom_i) ? LVL_HIGH : LVL_NORM;
    base_lvl[EV_BYPASS]  = LVL_NORM;
    base_lvl[EV_INJECT]  = LVL_NORM;
    base_lvl[EV_FWROLL]  = LVL_HIGH;
  end

  for (genvar k = 0; k < N; k++) begin : g_rule
    assign lvl_in[k] = rail_low_i ? LVL_WEAK : base_lvl[k];

    tre_rule #(.CNT_W(CNT_W), .DUR_W(DUR_W), .HOLD_CYC(HOLD_CYC)) i_rule (
      .clk(clk), .rst_n(rst_n), .cond_i(cond[k]), .gate_i(gate[k]),
      .lvl_i(lvl_in[k]), .snap_i(snap_now), .busy_i(busy[k]),
      .start_o(start_p[k]), .end_o(end_p[k]), .active_o(active[k]),
      .lvl_o(lvl_q[k]), .snap_o(snap_q[k]), .dur_o(dur_q[k])
    );
  end

  tre_evq #(.N(N), .DUR_W(DUR_W)) i_evq (
    .clk(clk), .rst_n(rst_n), .start_i(start_p), .end_i(end_p),
    .lvl_i(lvl_q), .snap_i(snap_q), .dur_i(dur_q), .busy_o(busy),
    .ev_valid_o(ev_valid_o), .ev_ready_i(ev_ready_i), .ev_start_o(ev_start_o),
    .ev_type_o(ev_type_o), .ev_lvl_o(ev_lvl_o), .ev_dur_o(ev_dur_o),
    .ev_snap_o(ev_snap_o)
  );

  assign pend_stb_o  = |start_p;
  assign pend_mask_o = start_p;
  assign tx_freeze_o = |active;

  a_r1_magnet_pair: assert property (@(posedge clk) disable iff (!rst_n)
    start_p[EV_MAGNET] |-> $past(mag_high_i && pf_anom_i));
  a_r11_freeze_with_marker: assert property (@(posedge clk) disable iff (!rst_n)
    pend_stb_o |-> tx_freeze_o);
  a_r7_weak_on_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_snap_o[SB_RAIL]) |-> (ev_lvl_o == LVL_WEAK));
  a_r6_fw_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_type_o == EV_FWROLL && !ev_snap_o[SB_RAIL]) |-> (ev_lvl_o == LVL_HIGH));
endmodule

// File: tb/test_tamper_rule_engine.sv
`timescale 1ns/1ps
module test_tamper_rule_engine;
  logic clk = 1'b0;
  logic rst_n;
  logic cover_raw, mag, pf, rev, vi, cur, fw, rail;
  logic [15:0] g_mag, g_rev, g_byp, g_vi;
  logic pend_stb, tx_freeze, ev_valid, ev_ready, ev_start;
  logic [6:0] pend_mask;
  logic [2:0] ev_type;
  logic [1:0] ev_lvl;
  logic [16:0] ev_dur;
  logic [7:0] ev_snap;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] last_snap;

  always #2.5 clk = ~clk;

  tamper_rule_engine i_tamper_rule_engine (
    .clk(clk), .rst_n(rst_n), .cover_raw_i(cover_raw), .mag_high_i(mag),
    .pf_anom_i(pf), .rev_sign_i(rev), .vi_bad_i(vi), .cur_bad_i(cur),
    .fw_mismatch_i(fw), .rail_low_i(rail), .gate_mag_i(g_mag),
    .gate_rev_i(g_rev), .gate_byp_i(g_byp), .gate_vi_i(g_vi),
    .pend_stb_o(pend_stb), .pend_mask_o(pend_mask), .tx_freeze_o(tx_freeze),
    .ev_valid_o(ev_valid), .ev_ready_i(ev_ready), .ev_start_o(ev_start),
    .ev_type_o(ev_type), .ev_lvl_o(ev_lvl), .ev_dur_o(ev_dur), .ev_snap_o(ev_snap)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wait for a record, check it, then take it with one ready cycle
  task automatic pop(input int e_start, input int e_type, input int e_lvl,
                     input int e_dur, input string tag);
    int w = 0;
    while (!ev_valid && w < 400) begin
      @(negedge clk);
      w++;
    end
    chk(ev_valid, {tag, " record present"}, int'(ev_valid), 1);
    if (ev_valid) begin
      chk(ev_start == e_start[0], {tag, " kind"}, int'(ev_start), e_start);
      chk(int'(ev_type) == e_type, {tag, " type"}, int'(ev_type), e_type);
      chk(int'(ev_lvl) == e_lvl, {tag, " level"}, int'(ev_lvl), e_lvl);
      if (e_dur >= 0) chk(int'(ev_dur) == e_dur, {tag, " duration"}, int'(ev_dur), e_dur);
      last_snap = ev_snap;
      ev_ready = 1'b1;
      @(negedge clk);
      ev_ready = 1'b0;
    end
  endtask

  task automatic expect_none(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (ev_valid || pend_stb) seen = 1;
    end
    chk(!seen, {tag, " no event"}, int'(seen), 0);
  endtask

  task automatic t_reset;
    chk(!ev_valid, "R12 valid after reset", int'(ev_valid), 0);
    chk(!pend_stb, "R12 pend after reset", int'(pend_stb), 0);
    chk(!tx_freeze, "R12 freeze after reset", int'(tx_freeze), 0);
  endtask

  task automatic t_magnet;
    g_mag = 16'd5;
    mag = 1'b1;
    expect_none(20, "R1 field alone");
    mag = 1'b0;
    idle(2);
    mag = 1'b1; pf = 1'b1;
    idle(5);
    chk(!pend_stb, "R1 not before gate", int'(pend_stb), 0);
    idle(1);
    chk(pend_stb, "R11 marker on trigger", int'(pend_stb), 1);
    chk(pend_mask == 7'b0000001, "R11 marker mask", int'(pend_mask), 1);
    chk(tx_freeze, "R11 freeze on trigger", int'(tx_freeze), 1);
    idle(1);
    chk(!pend_stb, "R11 marker one cycle", int'(pend_stb), 0);
    idle(3);
    mag = 1'b0; pf = 1'b0;
    idle(2);
    chk(!tx_freeze, "R11 freeze released", int'(tx_freeze), 0);
    pop(1, 0, 2, 0, "R1 magnet start");
    pop(0, 0, 2, 10, "R8 magnet end");
  endtask

  task automatic t_reverse;
    g_rev = 16'd3;
    rev = 1'b1; idle(3); rev = 1'b0;
    expect_none(20, "R2 short run");
    rev = 1'b1; idle(6); rev = 1'b0; idle(2);
    rev = 1'b1; idle(6); rev = 1'b0;
    idle(20);
    pop(1, 2, 1, 0, "R2 reverse start");
    pop(0, 2, 1, 6, "R2 reverse end");
    expect_none(10, "R9 no re-arm inside hold");
    rev = 1'b1; idle(6); rev = 1'b0;
    pop(1, 2, 1, 0, "R9 re-armed start");
    pop(0, 2, 1, 6, "R9 re-armed end");
    idle(20);
  endtask

  task automatic t_bypass_weak;
    g_byp = 16'd2;
    rail = 1'b1;
    cur = 1'b1; idle(4); cur = 1'b0;
    pop(1, 4, 0, 0, "R7 bypass weak start");
    chk(last_snap == 8'h90, "R13 snapshot bits", int'(last_snap), 8'h90);
    rail = 1'b0;
    pop(0, 4, 0, 4, "R3 bypass end");
    idle(20);
  endtask

  task automatic t_vi;
    g_vi = 16'd2;
    vi = 1'b1; idle(5); vi = 1'b0;
    pop(1, 1, 1, 0, "R4 neutral start");
    pop(0, 1, 1, 5, "R4 neutral end");
    idle(20);
    pf = 1'b1;
    expect_none(10, "R4 pf alone");
    vi = 1'b1; idle(4); vi = 1'b0;
    pop(1, 5, 1, 0, "R4 injection start");
    pop(0, 5, 1, 4, "R4 injection end");
    pf = 1'b0;
    idle(20);
  endtask

  task automatic t_cover;
    g_vi = 16'd1000;
    cover_raw = 1'b1; idle(2); cover_raw = 1'b0;
    expect_none(20, "R5 glitch");
    cover_raw = 1'b1; idle(15); cover_raw = 1'b0;
    pop(1, 3, 1, 0, "R5 cover start");
    pop(0, 3, 1, 15, "R5 cover end");
    idle(20);
    vi = 1'b1;
    cover_raw = 1'b1; idle(10);
    vi = 1'b0;
    idle(2); cover_raw = 1'b0;
    pop(1, 3, 2, 0, "R5 cover raised severity");
    pop(0, 3, 2, -1, "R5 cover raised end");
    idle(20);
    g_vi = 16'd2;
  endtask

  task automatic t_fw;
    fw = 1'b1; idle(1);
    chk(pend_stb && pend_mask == 7'b1000000, "R6 immediate marker", int'(pend_mask), 64);
    idle(4); fw = 1'b0;
    pop(1, 6, 2, 0, "R6 fw start");
    pop(0, 6, 2, 5, "R6 fw end");
    expect_none(20, "R6 reported once");
  endtask

  task automatic t_simul;
    g_rev = 16'd2; g_byp = 16'd2; g_vi = 16'd2;
    rev = 1'b1; cur = 1'b1; vi = 1'b1;
    idle(3);
    chk(pend_mask == 7'b0010110, "R11 joint mask", int'(pend_mask), 22);
    idle(3);
    rev = 1'b0; cur = 1'b0; vi = 1'b0;
    idle(10);
    chk(ev_valid && ev_type == 3'd1 && ev_start, "R10 held under back-pressure",
        int'(ev_type), 1);
    pop(1, 1, 1, 0, "R10 order 1");
    pop(1, 2, 1, 0, "R10 order 2");
    pop(1, 4, 1, 0, "R10 order 3");
    pop(0, 1, 1, 6, "R10 order 4");
    pop(0, 2, 1, 6, "R10 order 5");
    pop(0, 4, 1, 6, "R10 order 6");
    expect_none(20, "R10 queue drained");
  endtask

  initial begin
    rst_n = 1'b0; ev_ready = 1'b0;
    cover_raw = 0; mag = 0; pf = 0; rev = 0; vi = 0; cur = 0; fw = 0; rail = 0;
    g_mag = 16'd5; g_rev = 16'd3; g_byp = 16'd2; g_vi = 16'd2;
    last_snap = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_magnet();
    t_reverse();
    t_bypass_weak();
    t_vi();
    t_cover();
    t_fw();
    t_simul();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule